// File: doc/BRIEF.md
# Descriptor-Driven I2C Master Sequencer

This block scripts whole I2C transactions from two small tables of buffer descriptors, one for transmit and one for receive. Each descriptor carries a 16-bit status word, a 16-bit length and a 16-bit index into a shared byte RAM. Once software has filled the tables and set the enable, a start command makes the sequencer walk the transmit chain. For each ready entry it issues START, WRITE, READ and STOP commands to a byte-level bus engine. It fetches outgoing bytes from the RAM, stores incoming bytes through the next empty receive descriptor, and writes completion and error flags back into every descriptor it touches.

A transmit entry whose START flag is set and whose first byte has bit 0 set is a read. That byte goes out as the address and each remaining count of the entry clocks one byte in. The bit-level bus engine sits outside the block and answers each command with a one-cycle done strobe. The descriptor tables and the byte RAM also sit outside and are read with zero latency. A one-cycle done pulse and a sticky event register report how each sequence ended.

Top module: `dscr_i2c_master`

## Requirements
- R1: A sequence starts only when register 1 (command) is written with bit 7 (go) and bit 0 (master) both set, while register 0 (mode) bit 0 (enable) is 1 and no sequence is running. Any other write starts nothing and leaves the descriptors unchanged.
- R2: A transmit descriptor is processed only while its status bit 15 (ready) is set, and that bit is cleared when it is written back. The sequence ends at the first entry found not ready.
- R3: Transmit status bit 10 (start) makes the block issue a START command (op 0) before the first byte of that entry. Bytes go out as WRITE commands (op 1) in buffer order.
- R4: Transmit status bit 11 (last) issues a STOP command (op 3) after the entry's final byte and ends the sequence. Bit 13 (wrap), or reaching entry 3, returns the transmit pointer to entry 0.
- R5: In a read entry (start flag set, first byte bit 0 = 1), the first byte is written and the remaining length minus one bytes are fetched with READ commands (op 2). The last READ carries the no-acknowledge request, and the bytes are stored in order from the receive descriptor's buffer index.
- R6: A receive descriptor is used only while its status bit 15 (empty) is set, and that bit is cleared on write-back. If the entry is not empty, the read bytes are discarded, the entry is left unchanged and the sequence reports an error.
- R7: Read bytes beyond the receive length, or beyond 128 bytes, are not stored and set receive status bit 1 (overrun).
- R8: A no-acknowledge on a written byte sets transmit status bit 2, and a collision sets bit 0. The block then issues STOP, clears ready on that entry and abandons all later entries.
- R9: A transmit entry of length zero gets status bit 1 (underflow) and ready cleared, with no bus command, and ends the sequence with an error.
- R10: At the end of a sequence, `done` pulses for exactly one cycle. Register 2 (events) sets bit 0 on a clean end or bit 1 if any error occurred, and writing 1 to a bit clears it.
- R11: A bus command and its opcode stay presented until the engine returns its done strobe.
- R12: After reset, the registers read zero, no command is presented and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 command, 2 events |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| done | output | 1 | One-cycle end-of-sequence pulse |
| dsc_sel_rx | output | 1 | Descriptor table select, 1 = receive |
| dsc_idx | output | 2 | Descriptor entry index |
| dsc_status | input | 16 | Selected descriptor status word |
| dsc_len | input | 16 | Selected descriptor length |
| dsc_ptr | input | 16 | Selected descriptor buffer index |
| dsc_we | output | 1 | Write status back to the selected descriptor |
| dsc_wstatus | output | 16 | Status word written back |
| buf_addr | output | 8 | Byte RAM address |
| buf_rdata | input | 8 | Byte RAM read data |
| buf_we | output | 1 | Byte RAM write strobe |
| buf_wdata | output | 8 | Byte RAM write data |
| cmd_valid | output | 1 | Bus command presented |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte to write |
| cmd_nack | output | 1 | Answer this READ with no-acknowledge |
| eng_done | input | 1 | Engine finished the current command |
| eng_rdata | input | 8 | Byte read by the engine |
| eng_nak | input | 1 | Written byte was not acknowledged |
| eng_col | input | 1 | Collision seen during the written byte |

## Verification
Every cycle, the assertions check the engine handshake: a command and its opcode hold until done. They also check that write-backs always clear the ready or empty flag, that received bytes are stored only on an engine strobe, and that `done` is a single quiet-cycle pulse. Only the bench scenarios can show that the command stream matches the descriptor chain. The same holds for read-mode detection, overrun by length and by the 128-byte cap, abandonment after a no-acknowledge, wrap and end-of-table handling, and the event register contents.

// File: rtl/dim_pkg.sv
// Package: shared constants and types for the descriptor-driven I2C sequencer.
// Assumes descriptor status bit positions are fixed, because software and the
// sequencer both decode them.
package dim_pkg;
    localparam int TXB_READY = 15;
    localparam int TXB_WRAP  = 13;
    localparam int TXB_LAST  = 11;
    localparam int TXB_START = 10;
    localparam int TXB_NAK   = 2;
    localparam int TXB_UN    = 1;
    localparam int TXB_CL    = 0;
    localparam int RXB_EMPTY = 15;
    localparam int RXB_WRAP  = 13;
    localparam int RXB_OV    = 1;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_TFETCH, S_START, S_BYTE, S_RFETCH,
        S_STOP, S_RWB, S_TWB, S_FIN
    } seq_state_t;

    localparam logic [1:0] RA_MODE = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_EVT  = 2'd2;
endpackage

// File: rtl/dim_regs.sv
// Module: control registers. Holds the enable and master bits and the sticky
// event bits. It produces the go pulse. Assumes one register write per cycle.
// A hardware set of an event bit wins over a software clear in the same cycle.
module dim_regs
    import dim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       busy,
    input  logic       fin,
    input  logic       fin_err,
    output logic       go
);
    logic       en_q;
    logic       master_q;
    logic [1:0] evt_q;

    // go: start command with master bit, only when enabled and idle
    assign go = reg_we && (reg_addr == RA_CMD) && reg_wdata[7] && reg_wdata[0]
                && en_q && !busy;

    // register state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            master_q <= 1'b0;
            evt_q    <= 2'b00;
        end else begin
            if (reg_we && reg_addr == RA_MODE) en_q <= reg_wdata[0];
            if (reg_we && reg_addr == RA_CMD)  master_q <= reg_wdata[0];
            evt_q <= (evt_q & ~((reg_we && reg_addr == RA_EVT) ? reg_wdata[1:0] : 2'b00))
                     | (fin ? (fin_err ? 2'b10 : 2'b01) : 2'b00);
        end
    end

    // read mux
    always_comb begin
        case (reg_addr)
            RA_MODE: reg_rdata = {7'd0, en_q};
            RA_CMD:  reg_rdata = {7'd0, master_q};
            RA_EVT:  reg_rdata = {6'd0, evt_q};
            default: reg_rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/dim_ctrl.sv
// Module: sequencer. Walks the transmit descriptor chain and drives the byte
// engine commands. It moves bytes between the byte RAM and the engine and
// writes status back. Assumes the descriptor and RAM reads are combinational
// (zero latency). Assumes eng_done is a one-cycle strobe answering the
// presented command.
module dim_ctrl
    import dim_pkg::*;
#(
    parameter int NDESC  = 4,
    parameter int BUF_AW = 8,
    parameter int MAX_RX = 128,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              fin,
    output logic              fin_err,
    output logic              dsc_sel_rx,
    output logic [IDX_W-1:0]  dsc_idx,
    input  logic [15:0]       dsc_status,
    input  logic [15:0]       dsc_len,
    input  logic [15:0]       dsc_ptr,
    output logic              dsc_we,
    output logic [15:0]       dsc_wstatus,
    output logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_nack,
    input  logic              eng_done,
    input  logic [7:0]        eng_rdata,
    input  logic              eng_nak,
    input  logic              eng_col
);
    localparam logic [15:0]      RX_CAP   = 16'(MAX_RX);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDESC - 1);

    seq_state_t       state;
    logic [IDX_W-1:0] tx_idx, rx_idx;
    logic [15:0]      st, len, ptr, cnt;
    logic [15:0]      rx_st, rx_len, rx_ptr;
    logic             rd_mode, rx_ok, ov, abort, seq_err;
    logic [2:0]       err;

    logic [15:0] rd_off, rx_lim;
    logic        rd_byte, at_end, new_rd, rx_room;

    // byte-level decode of the current position in the entry
    assign rd_off  = cnt - 16'd1;
    assign rx_lim  = (rx_len > RX_CAP) ? RX_CAP : rx_len;
    assign rd_byte = rd_mode && (cnt != 16'd0);
    assign at_end  = (cnt == len - 16'd1);
    assign new_rd  = (cnt == 16'd0) && st[TXB_START] && buf_rdata[0];
    assign rx_room = rx_ok && (rd_off < rx_lim);

    // descriptor and RAM port steering
    assign dsc_sel_rx  = (state == S_RFETCH) || (state == S_RWB);
    assign dsc_idx     = dsc_sel_rx ? rx_idx : tx_idx;
    assign dsc_we      = (state == S_RWB) || (state == S_TWB);
    assign dsc_wstatus = (state == S_RWB)
                       ? ((rx_st & ~(16'd1 << RXB_EMPTY)) | (ov ? (16'd1 << RXB_OV) : 16'd0))
                       : ((st & ~(16'd1 << TXB_READY)) | {13'd0, err});
    assign buf_addr    = rd_byte ? (rx_ptr[BUF_AW-1:0] + rd_off[BUF_AW-1:0])
                                 : (ptr[BUF_AW-1:0] + cnt[BUF_AW-1:0]);
    assign buf_we      = (state == S_BYTE) && eng_done && rd_byte && rx_room;
    assign buf_wdata   = eng_rdata;

    // engine command presentation
    assign cmd_valid = (state == S_START) || (state == S_BYTE) || (state == S_STOP);
    assign cmd_op    = (state == S_START) ? OP_START
                     : (state == S_STOP)  ? OP_STOP
                     : (rd_byte ? OP_READ : OP_WRITE);
    assign cmd_wdata = buf_rdata;
    assign cmd_nack  = rd_byte && at_end;

    assign busy    = (state != S_IDLE);
    assign fin     = (state == S_FIN);
    assign fin_err = seq_err;

    // sequencer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            tx_idx  <= '0;
            rx_idx  <= '0;
            st      <= '0;
            len     <= '0;
            ptr     <= '0;
            cnt     <= '0;
            rx_st   <= '0;
            rx_len  <= '0;
            rx_ptr  <= '0;
            rd_mode <= 1'b0;
            rx_ok   <= 1'b0;
            ov      <= 1'b0;
            abort   <= 1'b0;
            seq_err <= 1'b0;
            err     <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    tx_idx  <= '0;
                    rx_idx  <= '0;
                    seq_err <= 1'b0;
                    state   <= S_TFETCH;
                end
                S_TFETCH: begin
                    st      <= dsc_status;
                    len     <= dsc_len;
                    ptr     <= dsc_ptr;
                    cnt     <= '0;
                    rd_mode <= 1'b0;
                    rx_ok   <= 1'b0;
                    ov      <= 1'b0;
                    abort   <= 1'b0;
                    err     <= '0;
                    if (!dsc_status[TXB_READY]) state <= S_FIN;
                    else if (dsc_len == 16'd0) begin
                        err[TXB_UN] <= 1'b1;
                        abort       <= 1'b1;
                        state       <= S_TWB;
                    end else if (dsc_status[TXB_START]) state <= S_START;
                    else state <= S_BYTE;
                end
                S_START: if (eng_done) state <= S_BYTE;
                S_BYTE: if (eng_done) begin
                    if (!rd_byte && (eng_nak || eng_col)) begin
                        err[TXB_NAK] <= eng_nak;
                        err[TXB_CL]  <= eng_col;
                        abort        <= 1'b1;
                        state        <= S_STOP;
                    end else begin
                        if (rd_byte && !rx_room) ov <= 1'b1;
                        cnt <= cnt + 16'd1;
                        if (at_end)
                            state <= st[TXB_LAST] ? S_STOP
                                   : ((rd_mode && rx_ok) ? S_RWB : S_TWB);
                        else if (new_rd) begin
                            rd_mode <= 1'b1;
                            state   <= S_RFETCH;
                        end
                    end
                end
                S_RFETCH: begin
                    rx_st  <= dsc_status;
                    rx_len <= dsc_len;
                    rx_ptr <= dsc_ptr;
                    rx_ok  <= dsc_status[RXB_EMPTY];
                    state  <= S_BYTE;
                end
                S_STOP: if (eng_done) state <= (rd_mode && rx_ok) ? S_RWB : S_TWB;
                S_RWB: begin
                    rx_idx  <= (rx_st[RXB_WRAP] || rx_idx == LAST_IDX) ? '0 : rx_idx + 1'b1;
                    seq_err <= seq_err | ov;
                    state   <= S_TWB;
                end
                S_TWB: begin
                    seq_err <= seq_err | (err != 3'd0) | (rd_mode && !rx_ok);
                    if (abort || st[TXB_LAST]) state <= S_FIN;
                    else begin
                        tx_idx <= (st[TXB_WRAP] || tx_idx == LAST_IDX) ? '0 : tx_idx + 1'b1;
                        state  <= S_TFETCH;
                    end
                end
                S_FIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dscr_i2c_master.sv
// Module: top of the descriptor-driven I2C master sequencer. Joins the register
// block and the sequencer. Assumes external zero-latency descriptor and byte
// RAM storage and an external byte-level bus engine.
module dscr_i2c_master #(
    parameter int NDESC  = 4,
    parameter int BUF_AW = 8,
    parameter int MAX_RX = 128,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              done,
    output logic              dsc_sel_rx,
    output logic [IDX_W-1:0]  dsc_idx,
    input  logic [15:0]       dsc_status,
    input  logic [15:0]       dsc_len,
    input  logic [15:0]       dsc_ptr,
    output logic              dsc_we,
    output logic [15:0]       dsc_wstatus,
    output logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_nack,
    input  logic              eng_done,
    input  logic [7:0]        eng_rdata,
    input  logic              eng_nak,
    input  logic              eng_col
);
    logic go, busy, fin, fin_err;

    // register block: enable, master, events
    dim_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .fin(fin), .fin_err(fin_err), .go(go)
    );

    // descriptor walker and command sequencer
    dim_ctrl #(.NDESC(NDESC), .BUF_AW(BUF_AW), .MAX_RX(MAX_RX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .fin(fin), .fin_err(fin_err),
        .dsc_sel_rx(dsc_sel_rx), .dsc_idx(dsc_idx), .dsc_status(dsc_status),
        .dsc_len(dsc_len), .dsc_ptr(dsc_ptr), .dsc_we(dsc_we), .dsc_wstatus(dsc_wstatus),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .eng_nak(eng_nak), .eng_col(eng_col)
    );

    assign done = fin;
endmodule

// File: rtl/dim_checker.sv
// Module: protocol checker for dscr_i2c_master, attached by bind. Observes the
// top-level ports only.
module dim_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        eng_done,
    input logic        done,
    input logic        dsc_we,
    input logic        dsc_sel_rx,
    input logic [15:0] dsc_wstatus,
    input logic        buf_we
);
    // R11: command held until the engine answers
    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !eng_done |=> cmd_valid && $stable(cmd_op));

    // R10: done is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: nothing else is in flight when the sequence reports its end
    assert_quiet_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && !dsc_we);

    // R2: transmit write-back always releases the ready flag
    assert_tx_ready_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we && !dsc_sel_rx |-> !dsc_wstatus[15]);

    // R6: receive write-back always releases the empty flag
    assert_rx_empty_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we && dsc_sel_rx |-> !dsc_wstatus[15]);

    // R5: a received byte is stored only when the engine delivers it
    assert_store_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> eng_done);
endmodule

bind dscr_i2c_master dim_checker u_dim_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .eng_done(eng_done), .done(done), .dsc_we(dsc_we), .dsc_sel_rx(dsc_sel_rx),
    .dsc_wstatus(dsc_wstatus), .buf_we(buf_we)
);

// File: tb/dscr_i2c_master_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios with models of the descriptor tables, the byte RAM
// and the byte engine.
module dscr_i2c_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        done;
    logic        dsc_sel_rx;
    logic [1:0]  dsc_idx;
    logic [15:0] dsc_status, dsc_len, dsc_ptr, dsc_wstatus;
    logic        dsc_we;
    logic [7:0]  buf_addr, buf_rdata, buf_wdata;
    logic        buf_we;
    logic        cmd_valid, cmd_nack;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_wdata;
    logic        eng_done = 1'b0, eng_nak = 1'b0, eng_col = 1'b0;
    logic [7:0]  eng_rdata = 8'd0;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    dscr_i2c_master uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .dsc_sel_rx(dsc_sel_rx), .dsc_idx(dsc_idx), .dsc_status(dsc_status),
        .dsc_len(dsc_len), .dsc_ptr(dsc_ptr), .dsc_we(dsc_we), .dsc_wstatus(dsc_wstatus),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .eng_nak(eng_nak), .eng_col(eng_col)
    );

    // storage models
    logic [15:0] tx_st [4], tx_len [4], tx_ptr [4];
    logic [15:0] rx_st [4], rx_len [4], rx_ptr [4];
    logic [7:0]  mem [256];

    assign dsc_status = dsc_sel_rx ? rx_st[dsc_idx]  : tx_st[dsc_idx];
    assign dsc_len    = dsc_sel_rx ? rx_len[dsc_idx] : tx_len[dsc_idx];
    assign dsc_ptr    = dsc_sel_rx ? rx_ptr[dsc_idx] : tx_ptr[dsc_idx];
    assign buf_rdata  = mem[buf_addr];

    always @(posedge clk) begin
        if (dsc_we) begin
            if (dsc_sel_rx) rx_st[dsc_idx] <= dsc_wstatus;
            else            tx_st[dsc_idx] <= dsc_wstatus;
        end
        if (buf_we) mem[buf_addr] <= buf_wdata;
    end

    // engine model and command log
    logic [9:0] log_ent [256];
    logic       log_nk  [256];
    int         log_n = 0;
    int         wr_cnt = 0;
    int         nak_at = -1, col_at = -1;
    logic [7:0] rd_val = 8'hC0;

    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                logic [1:0] op;
                logic [7:0] dat;
                logic       nk;
                op  = cmd_op;
                nk  = cmd_nack;
                dat = (op == 2'd1) ? cmd_wdata : ((op == 2'd2) ? rd_val : 8'd0);
                repeat (2) @(negedge clk);
                eng_done = 1'b1;
                if (op == 2'd1) begin
                    eng_nak = (wr_cnt == nak_at);
                    eng_col = (wr_cnt == col_at);
                    wr_cnt++;
                end
                if (op == 2'd2) begin
                    eng_rdata = rd_val;
                    rd_val    = rd_val + 8'd1;
                end
                if (log_n < 256) begin
                    log_ent[log_n] = {op, dat};
                    log_nk[log_n]  = nk;
                end
                log_n++;
                @(negedge clk);
                eng_done = 1'b0;
                eng_nak  = 1'b0;
                eng_col  = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            tx_st[i] = 0; tx_len[i] = 0; tx_ptr[i] = 0;
            rx_st[i] = 0; rx_len[i] = 0; rx_ptr[i] = 0;
        end
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        log_n = 0; wr_cnt = 0; nak_at = -1; col_at = -1; rd_val = 8'hC0;
        reg_write(2'd2, 8'h03);
    endtask

    // start and wait for done; returns whether done came and was one cycle
    task automatic run_seq(input logic [7:0] cmd, output logic got, output logic one);
        got = 1'b0; one = 1'b0;
        reg_write(2'd1, cmd);
        for (int i = 0; i < 5000 && !got; i++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        if (got) begin
            @(negedge clk);
            one = !done;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_log(input string tag, input int i, input logic [1:0] op, input logic [7:0] d);
        chk(tag, {22'd0, log_ent[i]}, {22'd0, op, d});
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R12 done low", {31'd0, done}, 0);
        chk("R12 no command", {31'd0, cmd_valid}, 0);
        reg_read(2'd0, r); chk("R12 mode reg", {24'd0, r}, 0);
        reg_read(2'd2, r); chk("R12 event reg", {24'd0, r}, 0);
    endtask

    task automatic t_disabled();
        logic g, o;
        clear_all();
        tx_st[0] = 16'h8C00; tx_len[0] = 1; tx_ptr[0] = 16'h10; mem[8'h10] = 8'hA0;
        run_seq(8'h81, g, o);
        chk("R1 no start when disabled", {31'd0, g}, 0);
        reg_write(2'd0, 8'h01);
        run_seq(8'h80, g, o);
        chk("R1 no start without master bit", {31'd0, g}, 0);
        chk("R1 no bus commands", log_n, 0);
        chk("R1 descriptor untouched", {16'd0, tx_st[0]}, 32'h8C00);
    endtask

    task automatic t_write();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'h8400; tx_len[0] = 3; tx_ptr[0] = 16'h10;
        mem[8'h10] = 8'hA0; mem[8'h11] = 8'h05; mem[8'h12] = 8'h11;
        tx_st[1] = 16'h8800; tx_len[1] = 2; tx_ptr[1] = 16'h20;
        mem[8'h20] = 8'h22; mem[8'h21] = 8'h33;
        run_seq(8'h81, g, o);
        chk("R10 done seen", {31'd0, g}, 1);
        chk("R10 done one cycle", {31'd0, o}, 1);
        chk("R11 command count", log_n, 7);
        chk_log("R3 start first", 0, 2'd0, 8'h00);
        chk_log("R3 byte0", 1, 2'd1, 8'hA0);
        chk_log("R3 byte1", 2, 2'd1, 8'h05);
        chk_log("R3 byte2", 3, 2'd1, 8'h11);
        chk_log("R2 next entry byte0", 4, 2'd1, 8'h22);
        chk_log("R2 next entry byte1", 5, 2'd1, 8'h33);
        chk_log("R4 stop after last", 6, 2'd3, 8'h00);
        chk("R2 tx0 ready cleared", {16'd0, tx_st[0]}, 32'h0400);
        chk("R2 tx1 ready cleared", {16'd0, tx_st[1]}, 32'h0800);
        reg_read(2'd2, r); chk("R10 event ok", {24'd0, r}, 1);
        reg_write(2'd2, 8'h02);
        reg_read(2'd2, r); chk("R10 clear other bit keeps", {24'd0, r}, 1);
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, r); chk("R10 w1c clears", {24'd0, r}, 0);
    endtask

    task automatic t_read();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'h8400; tx_len[0] = 2; tx_ptr[0] = 16'h10;
        mem[8'h10] = 8'hA0; mem[8'h11] = 8'h04;
        tx_st[1] = 16'h8C00; tx_len[1] = 4; tx_ptr[1] = 16'h20; mem[8'h20] = 8'hA1;
        rx_st[0] = 16'h8000; rx_len[0] = 3; rx_ptr[0] = 16'h40;
        run_seq(8'h81, g, o);
        chk("R5 command count", log_n, 9);
        chk_log("R3 repeated start", 3, 2'd0, 8'h00);
        chk_log("R5 address byte", 4, 2'd1, 8'hA1);
        chk_log("R5 read 0", 5, 2'd2, 8'hC0);
        chk_log("R5 read 2", 7, 2'd2, 8'hC2);
        chk("R5 no nack mid", {31'd0, log_nk[6]}, 0);
        chk("R5 nack last", {31'd0, log_nk[7]}, 1);
        chk_log("R4 stop", 8, 2'd3, 8'h00);
        chk("R5 stored 0", {24'd0, mem[8'h40]}, 32'hC0);
        chk("R5 stored 2", {24'd0, mem[8'h42]}, 32'hC2);
        chk("R6 rx empty cleared", {16'd0, rx_st[0]}, 0);
        chk("R2 tx1 status", {16'd0, tx_st[1]}, 32'h0C00);
        reg_read(2'd2, r); chk("R10 event ok after read", {24'd0, r}, 1);
    endtask

    task automatic t_rx_busy();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'h8C00; tx_len[0] = 3; tx_ptr[0] = 16'h10; mem[8'h10] = 8'hA1;
        rx_st[0] = 16'h0000; rx_len[0] = 4; rx_ptr[0] = 16'h40;
        run_seq(8'h81, g, o);
        chk("R6 nothing stored", {24'd0, mem[8'h40]}, 0);
        chk("R6 rx entry unchanged", {16'd0, rx_st[0]}, 0);
        reg_read(2'd2, r); chk("R6 error event", {24'd0, r}, 2);
    endtask

    task automatic t_overrun();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'h8C00; tx_len[0] = 4; tx_ptr[0] = 16'h10; mem[8'h10] = 8'hA1;
        rx_st[0] = 16'h8000; rx_len[0] = 2; rx_ptr[0] = 16'h50;
        run_seq(8'h81, g, o);
        chk("R7 first stored", {24'd0, mem[8'h50]}, 32'hC0);
        chk("R7 second stored", {24'd0, mem[8'h51]}, 32'hC1);
        chk("R7 excess dropped", {24'd0, mem[8'h52]}, 0);
        chk("R7 overrun flag", {16'd0, rx_st[0]}, 32'h0002);
        reg_read(2'd2, r); chk("R7 error event", {24'd0, r}, 2);
    endtask

    task automatic t_cap();
        logic g, o;
        clear_all();
        tx_st[0] = 16'h8C00; tx_len[0] = 131; tx_ptr[0] = 16'h10; mem[8'h10] = 8'hA1;
        rx_st[0] = 16'h8000; rx_len[0] = 200; rx_ptr[0] = 16'h80;
        run_seq(8'h81, g, o);
        chk("R7 reads issued", log_n, 133);
        chk("R7 byte 127 stored", {24'd0, mem[8'hFF]}, 32'h3F);
        chk("R7 byte 128 dropped", {24'd0, mem[8'h00]}, 0);
        chk("R7 cap overrun", {16'd0, rx_st[0]}, 32'h0002);
    endtask

    task automatic t_nak();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'h8400; tx_len[0] = 2; tx_ptr[0] = 16'h10;
        mem[8'h10] = 8'hA0; mem[8'h11] = 8'h01;
        tx_st[1] = 16'h8800; tx_len[1] = 1; tx_ptr[1] = 16'h20;
        nak_at = 0;
        run_seq(8'h81, g, o);
        chk("R8 nak command count", log_n, 3);
        chk_log("R8 stop after nak", 2, 2'd3, 8'h00);
        chk("R8 nak status", {16'd0, tx_st[0]}, 32'h0404);
        chk("R8 later entry abandoned", {16'd0, tx_st[1]}, 32'h8800);
        reg_read(2'd2, r); chk("R8 error event", {24'd0, r}, 2);
    endtask

    task automatic t_col();
        logic g, o;
        clear_all();
        tx_st[0] = 16'h8C00; tx_len[0] = 3; tx_ptr[0] = 16'h10;
        mem[8'h10] = 8'hA0; mem[8'h11] = 8'h01;
        col_at = 1;
        run_seq(8'h81, g, o);
        chk("R8 col command count", log_n, 4);
        chk_log("R8 stop after col", 3, 2'd3, 8'h00);
        chk("R8 col status", {16'd0, tx_st[0]}, 32'h0C01);
    endtask

    task automatic t_underflow();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'h8C00; tx_len[0] = 0;
        run_seq(8'h81, g, o);
        chk("R9 done", {31'd0, g}, 1);
        chk("R9 no bus command", log_n, 0);
        chk("R9 underflow status", {16'd0, tx_st[0]}, 32'h0C02);
        reg_read(2'd2, r); chk("R9 error event", {24'd0, r}, 2);
    endtask

    task automatic t_wrap();
        logic g, o; logic [7:0] r;
        clear_all();
        tx_st[0] = 16'hA400; tx_len[0] = 1; tx_ptr[0] = 16'h10; mem[8'h10] = 8'hA0;
        tx_st[1] = 16'h8800; tx_len[1] = 1; tx_ptr[1] = 16'h20;
        run_seq(8'h81, g, o);
        chk("R4 wrap command count", log_n, 2);
        chk("R4 wrap tx0 status", {16'd0, tx_st[0]}, 32'h2400);
        chk("R4 wrap skips tx1", {16'd0, tx_st[1]}, 32'h8800);
        reg_read(2'd2, r); chk("R4 wrap event ok", {24'd0, r}, 1);
        clear_all();
        tx_st[0] = 16'h8400; tx_len[0] = 1; tx_ptr[0] = 16'h10; mem[8'h10] = 8'hA0;
        for (int i = 1; i < 4; i++) begin
            tx_st[i] = 16'h8000; tx_len[i] = 1; tx_ptr[i] = 16'(8'h20 + i);
            mem[8'h20 + i] = 8'hB0 + 8'(i);
        end
        run_seq(8'h81, g, o);
        chk("R4 table end command count", log_n, 5);
        chk_log("R4 entry 3 byte", 4, 2'd1, 8'hB3);
        chk("R2 end at not ready", {31'd0, g}, 1);
    endtask

    task automatic t_notready();
        logic g, o; logic [7:0] r;
        clear_all();
        run_seq(8'h81, g, o);
        chk("R2 not ready done", {31'd0, g}, 1);
        chk("R2 not ready no command", log_n, 0);
        reg_read(2'd2, r); chk("R2 not ready event", {24'd0, r}, 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_write();
        t_read();
        t_rx_busy();
        t_overrun();
        t_cap();
        t_nak();
        t_col();
        t_underflow();
        t_wrap();
        t_notready();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule